// File: doc/BRIEF.md
# ATA PIO Timing Count Scaler

This block converts an ATA PIO transfer mode (0 to 6) and the system clock frequency in whole MHz into the cycle counts that a bus cycle generator needs. It produces seven counts: address setup, strobe width, recovery, write hold, read data hold, tristate delay and end-of-cycle hold. It also produces a two-bit timing multiplier code and a flag that tells the cycle generator whether to honour the device's ready line. Every count is the ceiling of the mode's nanosecond figure times the clock rate, and is stored in minus-one form.

One result can be too large for a six-bit field. In that case the block halves all seven counts together, rounding up, and doubles a shared multiplier. It repeats this once per clock until the strobe width fits. A one-cycle start pulse launches a conversion. `done_o` then rises and stays high, and the outputs hold their values until the next accepted start.

Top module: `pio_timing_scaler`

## Requirements
- R1: The nanosecond figures (setup/strobe/recovery/write hold/data hold/tristate/end hold) are: mode 0 70/165/0/30/5/30/20, mode 1 50/125/0/20/5/30/15, mode 2 30/100/0/15/5/30/10, mode 3 30/80/70/10/5/30/10, mode 4 25/70/25/10/5/30/10, mode 5 15/65/25/5/5/20/10, mode 6 10/55/20/5/5/20/10. Mode 7 uses the mode 0 figures.
- R2: Before scaling, each count is ceil(ns × MHz / 1000) minus one. The cycles-per-microsecond figure equals the MHz input.
- R3: A count whose ceiling is zero stays zero and does not wrap. A 0 MHz clock gives all counts zero, multiplier code 1 and no halving step.
- R4: While the strobe count is 64 or more, all seven counts become ceil(count/2) and the multiplier doubles. At `done_o` every count is below 64.
- R5: The multiplier code encodes the multiplier as follows: ×1 gives 1, ×2 gives 2, ×4 gives 0, ×8 or more gives 3.
- R6: `rdy_wait_en_o` is 1 for modes 0 to 4 and for mode 7, and 0 for modes 5 and 6.
- R7: Each clock performs exactly one halving step. With H halving steps, `done_o` is first high after H+3 rising edges, counting the edge that samples the start pulse.
- R8: While no start is accepted, `done_o` stays high and every output stays unchanged.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running conversion completes with its original mode and clock values.
- R10: After reset, `busy_o` and `done_o` are 0 and all seven counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| mode_i | input | 3 | PIO mode, sampled with an accepted start |
| clk_mhz_i | input | 12 | Clock rate in MHz, sampled with an accepted start |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Results valid and held |
| setup_o | output | 6 | Address setup count |
| strobe_o | output | 6 | Strobe width count |
| recov_o | output | 6 | Recovery count |
| whold_o | output | 6 | Write hold count |
| dhold_o | output | 6 | Read data hold count |
| triz_o | output | 6 | Tristate delay count |
| endhold_o | output | 6 | End-of-cycle hold count |
| mult_code_o | output | 2 | Encoded timing multiplier |
| rdy_wait_en_o | output | 1 | Honour device ready line |

## Verification
The situations hardest to reach from the ports are the deepest scaling runs, where a slow mode at a clock near 4 GHz needs four halvings, and the rounding edges, where a product lands exactly on a multiple of 1000. The bench sweeps every mode against a strided set of clock rates from 0 to 4095 MHz, with the endpoint included, and compares each result with an arithmetic model. It also fires a second start in the middle of a four-step run to confirm that the second start is ignored.

// File: rtl/pio_scaler_pkg.sv
package pio_scaler_pkg;
  localparam int NUM_T    = 7;
  localparam int T_SETUP  = 0;
  localparam int T_STROBE = 1;
  localparam int T_RECOV  = 2;
  localparam int T_WHOLD  = 3;
  localparam int T_DHOLD  = 4;
  localparam int T_TRIZ   = 5;
  localparam int T_END    = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SCALE = 2'd2,
    ST_DONE  = 2'd3
  } scl_state_e;

  // Field code for a multiplier of 2**e
  function automatic logic [1:0] mult_code(input int unsigned e);
    case (e)
      0:       return 2'd1;
      1:       return 2'd2;
      2:       return 2'd0;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/pio_mode_rom.sv
module pio_mode_rom
  import pio_scaler_pkg::*;
#(
  parameter int NS_W = 8
) (
  input  logic [2:0]                       mode_i,
  output logic [NUM_T-1:0][NS_W-1:0]       ns_o,
  output logic                             rdy_wait_o
);
  typedef logic [NUM_T-1:0][NS_W-1:0] ns_vec_t;

  function automatic ns_vec_t pack7(input int su, input int sw, input int rc,
                                    input int wh, input int dh, input int tz,
                                    input int eh);
    ns_vec_t v;
    v[T_SETUP]  = NS_W'(su);
    v[T_STROBE] = NS_W'(sw);
    v[T_RECOV]  = NS_W'(rc);
    v[T_WHOLD]  = NS_W'(wh);
    v[T_DHOLD]  = NS_W'(dh);
    v[T_TRIZ]   = NS_W'(tz);
    v[T_END]    = NS_W'(eh);
    return v;
  endfunction

  always_comb begin
    rdy_wait_o = 1'b1;
    case (mode_i)
      3'd1: ns_o = pack7(50, 125,  0, 20, 5, 30, 15);
      3'd2: ns_o = pack7(30, 100,  0, 15, 5, 30, 10);
      3'd3: ns_o = pack7(30,  80, 70, 10, 5, 30, 10);
      3'd4: ns_o = pack7(25,  70, 25, 10, 5, 30, 10);
      3'd5: begin
        ns_o       = pack7(15, 65, 25, 5, 5, 20, 10);
        rdy_wait_o = 1'b0;
      end
      3'd6: begin
        ns_o       = pack7(10, 55, 20, 5, 5, 20, 10);
        rdy_wait_o = 1'b0;
      end
      default: ns_o = pack7(70, 165, 0, 30, 5, 30, 20);
    endcase
  end
endmodule

// File: rtl/pio_ns2cyc.sv
module pio_ns2cyc #(
  parameter int NS_W   = 8,
  parameter int CLK_W  = 12,
  parameter int PROD_W = 24,
  parameter int CNT_W  = 11
) (
  input  logic [NS_W-1:0]  ns_i,
  input  logic [CLK_W-1:0] mhz_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [PROD_W-1:0] NS_PER_US = PROD_W'(1000);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] cyc;

  always_comb begin
    prod  = PROD_W'(ns_i) * PROD_W'(mhz_i);
    cyc   = (prod + NS_PER_US - PROD_W'(1)) / NS_PER_US;
    cnt_o = (cyc == '0) ? '0 : CNT_W'(cyc - PROD_W'(1));
  end
endmodule

// File: rtl/pio_halve_fsm.sv
module pio_halve_fsm
  import pio_scaler_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int FIELD_W = 6,
  parameter int EXP_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [NUM_T-1:0][CNT_W-1:0]    conv_i,
  output logic [NUM_T-1:0][FIELD_W-1:0]  fld_o,
  output logic [EXP_W-1:0]               exp_o,
  output logic                           accept_o,
  output logic                           busy_o,
  output logic                           done_o
);
  localparam logic [CNT_W-1:0] FIT_LIM = CNT_W'(1) << FIELD_W;

  scl_state_e                  state_q, state_d;
  logic [NUM_T-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0]            exp_q, exp_d;
  logic                        cnt_en, exp_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    exp_d    = exp_q;
    cnt_en   = 1'b0;
    exp_en   = 1'b0;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        cnt_d   = conv_i;
        exp_d   = '0;
        cnt_en  = 1'b1;
        exp_en  = 1'b1;
        state_d = ST_SCALE;
      end
      ST_SCALE: begin
        if (cnt_q[T_STROBE] >= FIT_LIM) begin
          for (int k = 0; k < NUM_T; k++) begin
            cnt_d[k] = (cnt_q[k] >> 1) + CNT_W'(cnt_q[k][0]);
          end
          exp_d  = exp_q + EXP_W'(1);
          cnt_en = 1'b1;
          exp_en = 1'b1;
        end else begin
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      exp_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (exp_en) exp_q <= exp_d;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_T; k++) begin
      fld_o[k] = cnt_q[k][FIELD_W-1:0];
    end
  end

  assign exp_o  = exp_q;
  assign busy_o = (state_q == ST_LOAD) || (state_q == ST_SCALE);
  assign done_o = (state_q == ST_DONE);

  AST_FIT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q[T_STROBE] < FIT_LIM)); // R4
  AST_HALVE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCALE && cnt_q[T_STROBE] >= FIT_LIM)
      |=> (cnt_q[T_STROBE] < $past(cnt_q[T_STROBE]) && exp_q == $past(exp_q) + EXP_W'(1))); // R4
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(cnt_q) && $stable(exp_q))); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (state_q != ST_LOAD)); // R9
endmodule

// File: rtl/pio_timing_scaler.sv
module pio_timing_scaler
  import pio_scaler_pkg::*;
#(
  parameter int CLK_W   = 12,
  parameter int NS_W    = 8,
  parameter int PROD_W  = 24,
  parameter int FIELD_W = 6,
  parameter int EXP_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         mode_i,
  input  logic [CLK_W-1:0]   clk_mhz_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FIELD_W-1:0] setup_o,
  output logic [FIELD_W-1:0] strobe_o,
  output logic [FIELD_W-1:0] recov_o,
  output logic [FIELD_W-1:0] whold_o,
  output logic [FIELD_W-1:0] dhold_o,
  output logic [FIELD_W-1:0] triz_o,
  output logic [FIELD_W-1:0] endhold_o,
  output logic [1:0]         mult_code_o,
  output logic               rdy_wait_en_o
);
  // Wide enough for the largest ns figure times the largest clock rate
  localparam int CNT_W = NS_W + CLK_W - 9;

  logic [2:0]                    mode_q;
  logic [CLK_W-1:0]              mhz_q;
  logic                          accept;
  logic [NUM_T-1:0][NS_W-1:0]    ns_vec;
  logic [NUM_T-1:0][CNT_W-1:0]   conv_vec;
  logic [NUM_T-1:0][FIELD_W-1:0] fld_vec;
  logic [EXP_W-1:0]              exp_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mhz_q  <= '0;
    end else if (accept) begin
      mode_q <= mode_i;
      mhz_q  <= clk_mhz_i;
    end
  end

  pio_mode_rom #(.NS_W(NS_W)) u_rom (
    .mode_i     (mode_q),
    .ns_o       (ns_vec),
    .rdy_wait_o (rdy_wait_en_o)
  );

  for (genvar g = 0; g < NUM_T; g++) begin : g_conv
    pio_ns2cyc #(
      .NS_W   (NS_W),
      .CLK_W  (CLK_W),
      .PROD_W (PROD_W),
      .CNT_W  (CNT_W)
    ) u_conv (
      .ns_i  (ns_vec[g]),
      .mhz_i (mhz_q),
      .cnt_o (conv_vec[g])
    );
  end

  pio_halve_fsm #(
    .CNT_W   (CNT_W),
    .FIELD_W (FIELD_W),
    .EXP_W   (EXP_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .conv_i   (conv_vec),
    .fld_o    (fld_vec),
    .exp_o    (exp_val),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  assign setup_o     = fld_vec[T_SETUP];
  assign strobe_o    = fld_vec[T_STROBE];
  assign recov_o     = fld_vec[T_RECOV];
  assign whold_o     = fld_vec[T_WHOLD];
  assign dhold_o     = fld_vec[T_DHOLD];
  assign triz_o      = fld_vec[T_TRIZ];
  assign endhold_o   = fld_vec[T_END];
  assign mult_code_o = mult_code(int'(exp_val));

  AST_FAST_MODES_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (mode_q == 3'd5 || mode_q == 3'd6)) |-> !rdy_wait_en_o); // R6
  AST_ZERO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mhz_q == '0) |-> (strobe_o == '0 && mult_code_o == 2'd1)); // R3
  AST_INPUTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(mode_q) || !busy_o)); // R9
endmodule

// File: tb/pio_timing_scaler_tb.sv
module pio_timing_scaler_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start_i, busy_o, done_o, rdy_wait_en_o;
  logic [2:0]  mode_i;
  logic [11:0] clk_mhz_i;
  logic [5:0]  setup_o, strobe_o, recov_o, whold_o, dhold_o, triz_o, endhold_o;
  logic [1:0]  mult_code_o;
  int n_run = 0, n_fail = 0;

  pio_timing_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .clk_mhz_i(clk_mhz_i), .busy_o(busy_o), .done_o(done_o),
    .setup_o(setup_o), .strobe_o(strobe_o), .recov_o(recov_o),
    .whold_o(whold_o), .dhold_o(dhold_o), .triz_o(triz_o),
    .endhold_o(endhold_o), .mult_code_o(mult_code_o),
    .rdy_wait_en_o(rdy_wait_en_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ns_fig(input int mode, input int idx);
    int t[7];
    case (mode)
      1: t = '{50, 125,  0, 20, 5, 30, 15};
      2: t = '{30, 100,  0, 15, 5, 30, 10};
      3: t = '{30,  80, 70, 10, 5, 30, 10};
      4: t = '{25,  70, 25, 10, 5, 30, 10};
      5: t = '{15,  65, 25,  5, 5, 20, 10};
      6: t = '{10,  55, 20,  5, 5, 20, 10};
      default: t = '{70, 165, 0, 30, 5, 30, 20};
    endcase
    return t[idx];
  endfunction

  int e_cnt[7];
  int e_h, e_code, e_rdy;

  task automatic model(input int mode, input int f);
    for (int k = 0; k < 7; k++) begin
      e_cnt[k] = (ns_fig(mode, k) * f + 999) / 1000;
      if (e_cnt[k] > 0) e_cnt[k] = e_cnt[k] - 1;
    end
    e_h = 0;
    while (e_cnt[1] >= 64) begin
      for (int k = 0; k < 7; k++) e_cnt[k] = (e_cnt[k] + 1) / 2;
      e_h++;
    end
    case (e_h)
      0: e_code = 1;
      1: e_code = 2;
      2: e_code = 0;
      default: e_code = 3;
    endcase
    e_rdy = (mode == 5 || mode == 6) ? 0 : 1;
  endtask

  function automatic int act_fld(input int k);
    case (k)
      0: return int'(setup_o);
      1: return int'(strobe_o);
      2: return int'(recov_o);
      3: return int'(whold_o);
      4: return int'(dhold_o);
      5: return int'(triz_o);
      default: return int'(endhold_o);
    endcase
  endfunction

  task automatic compare(input int mode, input int f);
    string tag;
    model(mode, f);
    for (int k = 0; k < 7; k++) begin
      if (e_h > 0) tag = "R4";
      else if (f < 8) tag = "R3";
      else if (mode == 7) tag = "R1";
      else tag = "R2";
      chk(tag, $sformatf("mode %0d f %0d count %0d", mode, f, k), act_fld(k), e_cnt[k]);
    end
    chk("R5", $sformatf("mult code mode %0d f %0d", mode, f), int'(mult_code_o), e_code);
    chk("R6", $sformatf("ready wait mode %0d", mode), int'(rdy_wait_en_o), e_rdy);
  endtask

  task automatic run(input int mode, input int f);
    int n;
    @(negedge clk);
    mode_i = 3'(mode); clk_mhz_i = 12'(f); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    compare(mode, f);
    chk("R7", $sformatf("latency mode %0d f %0d", mode, f), n, e_h + 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; clk_mhz_i = '0;
    repeat (3) @(negedge clk);
    chk("R10", "busy after reset", int'(busy_o), 0);
    chk("R10", "done after reset", int'(done_o), 0);
    chk("R10", "strobe after reset", int'(strobe_o), 0);
    chk("R10", "setup after reset", int'(setup_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 zero clock and R1 mode 7 fallback
    run(0, 0);
    run(7, 4095);
    run(7, 133);

    // Sweep every mode over a strided range of clock rates
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 4096; f += 37) run(m, f);
      run(m, 4095);
      run(m, 1000);
      run(m, 200);
    end

    // R8 result held while idle
    run(3, 777);
    begin
      logic [5:0] s_hold;
      s_hold = strobe_o;
      repeat (6) @(negedge clk);
      chk("R8", "done held", int'(done_o), 1);
      chk("R8", "strobe held", int'(strobe_o), int'(s_hold));
    end
    compare(3, 777);

    // R9 start during busy is ignored
    @(negedge clk);
    mode_i = 3'd0; clk_mhz_i = 12'd4095; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R9", "busy mid run", int'(busy_o), 1);
    mode_i = 3'd6; clk_mhz_i = 12'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    begin
      int n = 0;
      while (!done_o && n < 40) begin
        @(negedge clk);
        n++;
      end
    end
    model(0, 4095);
    chk("R9", "strobe keeps first request", int'(strobe_o), e_cnt[1]);
    chk("R9", "code keeps first request", int'(mult_code_o), e_code);
    chk("R9", "ready flag keeps first request", int'(rdy_wait_en_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule